// File: doc/BRIEF.md
# Strictly Ordered Device Access Sequencer

This block sits between a load/store unit and a 64-bit AXI manager port and handles every access aimed at strictly ordered device memory. A request names a direction, an access size (byte, halfword or word), a register count, a start address and the store data for all registers. The block checks the address against the access size and turns the request into one or more INCR transactions. Each transaction carries the access's own size, and its byte strobes sit on the lanes that the address selects.

A multiple-register access always moves 32-bit words. A multiple load becomes one single-beat read per word. A multiple store is cut into bursts of at most two beats, and a two-beat burst always starts on an 8-byte boundary. Only one transaction is in flight at a time. The next address phase starts only after the previous write response or read beat has been received, so the device sees the accesses in program order. Each completed transaction is reported on a return port, with read data extracted from its lanes and zero-extended.

Top module: `devAxiSeq`

## Requirements
- R1: A request with count 1 and size code 0 (byte), 1 (halfword) or 2 (word) produces exactly one transaction with length field 0 (one beat) and AxSIZE equal to the size code.
- R2: Write strobes: a byte sets only lane addr[2:0]; a halfword sets 2'b11 shifted left by addr[2:0]; a word sets 8'h0F when addr[2] is 0 and 8'hF0 when addr[2] is 1.
- R3: A halfword at an odd address, a word or multiple access (count > 1) whose addr[1:0] is not 0, or size code 3 raises faultFlag one cycle after acceptance and issues no transaction.
- R4: Every transaction of a request with count > 1 uses AxSIZE 2 (32 bits), regardless of the requested size.
- R5: A multiple load of N words issues N reads with length field 0, at addresses start, start+4, and so on up to start+4(N-1).
- R6: A multiple store issues a one-beat burst when the current word address has addr[2] = 1 or only one word is left; otherwise it issues a two-beat burst (length field 1). Five words from offset 0 give lengths 2,2,1, and from offset 4 give 1,2,2.
- R7: AxBURST is always 2'b01 (INCR) and no write burst crosses a 32-byte boundary.
- R8: bReady and rReady are 1 while lowPower is 0 and 0 while lowPower is 1. No request is accepted while lowPower is 1.
- R9: At most one transaction is outstanding. No address channel is valid between an address handshake and the matching write response or read beat, and an address held valid without ready keeps its value.
- R10: The return port pulses rspValid once per completed transaction. rspData is the read lane selected by addr[2:0] and the size, zero-extended (0 for writes). rspErr is 1 when the response code is not 0. rspLast marks the final transaction of the request.
- R11: In every write beat, each lane enabled by the strobe carries the matching byte of the register being stored, with the byte at the lowest enabled lane taken from bit 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowPower | input | 1 | Low-power mode: drops response readies, blocks requests |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reqCount | input | CNT_W | Number of registers (1..MAX_REGS) |
| reqAddr | input | ADDR_W | Start byte address |
| reqWdata | input | 32*MAX_REGS | Store data, register k in bits [32k+31:32k] |
| faultFlag | output | 1 | One-cycle alignment-fault pulse |
| rspValid | output | 1 | One transaction completed |
| rspData | output | 32 | Zero-extended read data |
| rspErr | output | 1 | Non-OKAY response |
| rspLast | output | 1 | Final transaction of the request |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| arAddr | output | ADDR_W | Read address |
| arLen | output | 8 | Read burst length minus one |
| arSize | output | 3 | Read transfer size |
| arBurst | output | 2 | Read burst type |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awAddr | output | ADDR_W | Write address |
| awLen | output | 8 | Write burst length minus one |
| awSize | output | 3 | Write transfer size |
| awBurst | output | 2 | Write burst type |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | output | 64 | Write data |
| wStrb | output | 8 | Write byte strobes |
| wLast | output | 1 | Final beat of a write burst |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |
| bResp | input | 2 | Write response code |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |
| rData | input | 64 | Read data |
| rResp | input | 2 | Read response code |

## Verification
The assertions watch, on every cycle, the channel-level rules: the burst type is always INCR, reads are single-beat, pairs are 8-byte aligned and 32-bit, no write crosses 32 bytes, the two address channels are never valid together, a stalled address holds its value, the readies follow lowPower, a fault is never followed by bus activity, and the strobe population is 1, 2 or 4. Only the bench scenarios can show that the addresses step through the right sequence and that the burst split follows the word parity. They also show that strobes and data lanes match the address, that read lanes are extracted and zero-extended correctly, that response codes and the last-transaction marker reach the return port, and that no new address appears while a response is pending.

// File: rtl/devSeqPkg.sv
package devSeqPkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDAT, S_WRSP, S_RDAT} seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic advance;   // step to the next transaction
    logic beatNext;  // step to second beat of a pair
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isWrite;
    logic lastBurst;
    logic lastBeat;
  } dpStatus_t;
endpackage

// File: rtl/devSeqDp.sv
module devSeqDp
  import devSeqPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_REGS = 8,
  parameter int CNT_W    = $clog2(MAX_REGS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              ctl,
  output dpStatus_t               st,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [CNT_W-1:0]        reqCount,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [32*MAX_REGS-1:0]  reqWdata,
  output logic                    reqFault,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [7:0]              axLen,
  output logic [2:0]              axSize,
  output logic [63:0]             wData,
  output logic [7:0]              wStrb,
  input  logic [63:0]             rData,
  input  logic [1:0]              rResp,
  input  logic [1:0]              bResp,
  output logic [31:0]             rspData,
  output logic                    rspErr
);
  logic [ADDR_W-1:0]      addrQ;
  logic [CNT_W-1:0]       remQ;
  logic [CNT_W-1:0]       idxQ;
  logic [1:0]             sizeQ;
  logic                   writeQ;
  logic                   multiQ;
  logic                   beatQ;
  logic [32*MAX_REGS-1:0] dataQ;

  logic [1:0]       burstLen;
  logic [2:0]       beatAddr;
  logic [CNT_W-1:0] wordSel;
  logic [31:0]      curWord;
  logic [63:0]      rShift;
  logic             reqMulti;

  // alignment check on the incoming request
  assign reqMulti = reqCount > CNT_W'(1);
  always_comb begin
    if (reqMulti)
      reqFault = reqAddr[1:0] != 2'b00;
    else begin
      unique case (reqSize)
        SZ_BYTE: reqFault = 1'b0;
        SZ_HALF: reqFault = reqAddr[0];
        SZ_WORD: reqFault = reqAddr[1:0] != 2'b00;
        default: reqFault = 1'b1;
      endcase
    end
  end

  // pairs only for stores, on an even word, with two or more words left
  assign burstLen = (writeQ && multiQ && !addrQ[2] && remQ >= CNT_W'(2)) ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      remQ   <= '0;
      idxQ   <= '0;
      sizeQ  <= SZ_BYTE;
      writeQ <= 1'b0;
      multiQ <= 1'b0;
      beatQ  <= 1'b0;
      dataQ  <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      remQ   <= reqCount;
      idxQ   <= '0;
      sizeQ  <= reqMulti ? SZ_WORD : reqSize;
      writeQ <= reqWrite;
      multiQ <= reqMulti;
      beatQ  <= 1'b0;
      dataQ  <= reqWdata;
    end else if (ctl.advance) begin
      addrQ <= addrQ + ADDR_W'({burstLen, 2'b00});
      remQ  <= remQ - CNT_W'(burstLen);
      idxQ  <= idxQ + CNT_W'(burstLen);
      beatQ <= 1'b0;
    end else if (ctl.beatNext) begin
      beatQ <= 1'b1;
    end
  end

  assign st.isWrite   = writeQ;
  assign st.lastBurst = remQ == CNT_W'(burstLen);
  assign st.lastBeat  = beatQ == (burstLen == 2'd2);

  assign busAddr = addrQ;
  assign axLen   = {7'd0, burstLen == 2'd2};
  assign axSize  = {1'b0, sizeQ};

  // write lanes
  assign beatAddr = addrQ[2:0] + {beatQ, 2'b00};
  assign wordSel  = idxQ + CNT_W'(beatQ);
  assign curWord  = dataQ[wordSel*32 +: 32];

  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: begin
        wData = {8{curWord[7:0]}};
        wStrb = 8'h01 << beatAddr;
      end
      SZ_HALF: begin
        wData = {4{curWord[15:0]}};
        wStrb = 8'h03 << beatAddr;
      end
      default: begin
        wData = {2{curWord}};
        wStrb = beatAddr[2] ? 8'hF0 : 8'h0F;
      end
    endcase
  end

  // read lane extraction
  assign rShift = rData >> {addrQ[2:0], 3'b000};
  always_comb begin
    if (writeQ)
      rspData = '0;
    else begin
      unique case (sizeQ)
        SZ_BYTE: rspData = {24'd0, rShift[7:0]};
        SZ_HALF: rspData = {16'd0, rShift[15:0]};
        default: rspData = rShift[31:0];
      endcase
    end
  end

  assign rspErr = writeQ ? (bResp != 2'b00) : (rResp != 2'b00);
endmodule

// File: rtl/devSeqCtl.sv
module devSeqCtl
  import devSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowPower,
  input  logic       reqValid,
  input  logic       reqFault,
  output logic       reqReady,
  output logic       faultFlag,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       arValid,
  input  logic       arReady,
  output logic       awValid,
  input  logic       awReady,
  output logic       wValid,
  input  logic       wReady,
  output logic       wLast,
  input  logic       bValid,
  output logic       bReady,
  input  logic       rValid,
  output logic       rReady,
  output logic       rspValid,
  output logic       rspLast
);
  seqState_e stateQ, stateD;
  logic accept, bDone, rDone, faultQ;

  assign reqReady = (stateQ == S_IDLE) && !lowPower;
  assign accept   = reqValid && reqReady;
  assign bReady   = !lowPower;
  assign rReady   = !lowPower;
  assign arValid  = (stateQ == S_ADDR) && !st.isWrite;
  assign awValid  = (stateQ == S_ADDR) && st.isWrite;
  assign wValid   = stateQ == S_WDAT;
  assign wLast    = wValid && st.lastBeat;
  assign bDone    = (stateQ == S_WRSP) && bValid && bReady;
  assign rDone    = (stateQ == S_RDAT) && rValid && rReady;
  assign rspValid = bDone || rDone;
  assign rspLast  = rspValid && st.lastBurst;

  always_comb begin
    ctl.load     = accept && !reqFault;
    ctl.advance  = rspValid && !st.lastBurst;
    ctl.beatNext = wValid && wReady && !st.lastBeat;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: if (accept && !reqFault) stateD = S_ADDR;
      S_ADDR: begin
        if (awValid && awReady) stateD = S_WDAT;
        else if (arValid && arReady) stateD = S_RDAT;
      end
      S_WDAT: if (wReady && st.lastBeat) stateD = S_WRSP;
      S_WRSP: if (bDone) stateD = st.lastBurst ? S_IDLE : S_ADDR;
      S_RDAT: if (rDone) stateD = st.lastBurst ? S_IDLE : S_ADDR;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      faultQ <= accept && reqFault;
    end
  end

  assign faultFlag = faultQ;
endmodule

// File: rtl/devAxiSeq.sv
module devAxiSeq
  import devSeqPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_REGS = 8,
  localparam int CNT_W   = $clog2(MAX_REGS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lowPower,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [1:0]             reqSize,
  input  logic [CNT_W-1:0]       reqCount,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [32*MAX_REGS-1:0] reqWdata,
  output logic                   faultFlag,
  output logic                   rspValid,
  output logic [31:0]            rspData,
  output logic                   rspErr,
  output logic                   rspLast,
  output logic                   arValid,
  input  logic                   arReady,
  output logic [ADDR_W-1:0]      arAddr,
  output logic [7:0]             arLen,
  output logic [2:0]             arSize,
  output logic [1:0]             arBurst,
  output logic                   awValid,
  input  logic                   awReady,
  output logic [ADDR_W-1:0]      awAddr,
  output logic [7:0]             awLen,
  output logic [2:0]             awSize,
  output logic [1:0]             awBurst,
  output logic                   wValid,
  input  logic                   wReady,
  output logic [63:0]            wData,
  output logic [7:0]             wStrb,
  output logic                   wLast,
  input  logic                   bValid,
  output logic                   bReady,
  input  logic [1:0]             bResp,
  input  logic                   rValid,
  output logic                   rReady,
  input  logic [63:0]            rData,
  input  logic [1:0]             rResp
);
  ctlStrobe_t        ctl;
  dpStatus_t         st;
  logic              reqFault;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0]        axLen;
  logic [2:0]        axSize;

  devSeqCtl u_ctl (
    .clk(clk), .rstN(rstN), .lowPower(lowPower),
    .reqValid(reqValid), .reqFault(reqFault), .reqReady(reqReady),
    .faultFlag(faultFlag), .st(st), .ctl(ctl),
    .arValid(arValid), .arReady(arReady),
    .awValid(awValid), .awReady(awReady),
    .wValid(wValid), .wReady(wReady), .wLast(wLast),
    .bValid(bValid), .bReady(bReady),
    .rValid(rValid), .rReady(rReady),
    .rspValid(rspValid), .rspLast(rspLast)
  );

  devSeqDp #(.ADDR_W(ADDR_W), .MAX_REGS(MAX_REGS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .st(st),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqCount(reqCount),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqFault(reqFault),
    .busAddr(busAddr), .axLen(axLen), .axSize(axSize),
    .wData(wData), .wStrb(wStrb),
    .rData(rData), .rResp(rResp), .bResp(bResp),
    .rspData(rspData), .rspErr(rspErr)
  );

  assign arAddr  = busAddr;
  assign awAddr  = busAddr;
  assign arLen   = axLen;
  assign awLen   = axLen;
  assign arSize  = axSize;
  assign awSize  = axSize;
  assign arBurst = BURST_INCR;
  assign awBurst = BURST_INCR;
endmodule

// File: rtl/devAxiSeqChk.sv
module devAxiSeqChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lowPower,
  input logic              faultFlag,
  input logic              reqReady,
  input logic              arValid,
  input logic [7:0]        arLen,
  input logic [1:0]        arBurst,
  input logic              awValid,
  input logic              awReady,
  input logic [ADDR_W-1:0] awAddr,
  input logic [7:0]        awLen,
  input logic [2:0]        awSize,
  input logic [1:0]        awBurst,
  input logic              wValid,
  input logic [7:0]        wStrb,
  input logic              bReady,
  input logic              rReady
);
  p_one_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(arValid && awValid) && !(arValid && wValid));

  p_aw_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr));

  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> arLen == 8'd0);

  p_incr_rd_r7: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> arBurst == 2'b01);

  p_incr_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> awBurst == 2'b01);

  p_no_cross_r7: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (int'(awAddr[4:0]) + ((int'(awLen) + 1) << awSize)) <= 32);

  p_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    awValid && awLen != 8'd0 |-> awLen == 8'd1 && awAddr[2:0] == 3'd0 && awSize == 3'd2);

  p_fault_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> !arValid && !awValid && !wValid);

  p_strb_pop_r2: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> ($countones(wStrb) == 1 || $countones(wStrb) == 2 || $countones(wStrb) == 4));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    bReady == !lowPower && rReady == !lowPower && (lowPower -> !reqReady));
endmodule

bind devAxiSeq devAxiSeqChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .lowPower(lowPower), .faultFlag(faultFlag),
  .reqReady(reqReady), .arValid(arValid), .arLen(arLen), .arBurst(arBurst),
  .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen),
  .awSize(awSize), .awBurst(awBurst), .wValid(wValid), .wStrb(wStrb),
  .bReady(bReady), .rReady(rReady)
);

// File: tb/devAxiSeq_tb.sv
`timescale 1ns/1ps
module devAxiSeq_tb;
  localparam int MAXR = 8;
  localparam int CW   = $clog2(MAXR + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, lowPower, reqValid, reqReady, reqWrite, faultFlag;
  logic [1:0] reqSize;
  logic [CW-1:0] reqCount;
  logic [31:0] reqAddr;
  logic [32*MAXR-1:0] reqWdata;
  logic rspValid, rspErr, rspLast;
  logic [31:0] rspData;
  logic arValid, arReady, awValid, awReady, wValid, wReady, wLast;
  logic [31:0] arAddr, awAddr;
  logic [7:0] arLen, awLen, wStrb;
  logic [2:0] arSize, awSize;
  logic [1:0] arBurst, awBurst, bResp, rResp;
  logic [63:0] wData, rData;
  logic bValid, bReady, rValid, rReady;

  devAxiSeq #(.ADDR_W(32), .MAX_REGS(MAXR)) u_dut (.*);

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finishRun();
  end

  task automatic pause(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!arValid && !awValid, "R9 no address while response pending", {arValid, awValid}, 0);
    end
  endtask

  function automatic logic [7:0] expStrb(input logic [1:0] sz, input logic [2:0] a);
    case (sz)
      2'd0: return 8'h01 << a;
      2'd1: return 8'h03 << a;
      default: return a[2] ? 8'hF0 : 8'h0F;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] sz, input logic [2:0] a, input logic [63:0] d);
    logic [63:0] s = d >> (a * 8);
    case (sz)
      2'd0: return {24'd0, s[7:0]};
      2'd1: return {16'd0, s[15:0]};
      default: return s[31:0];
    endcase
  endfunction

  function automatic bit isFault(input logic [1:0] sz, input int cnt, input logic [31:0] a);
    if (cnt > 1) return a[1:0] != 0;
    if (sz == 2'd3) return 1;
    if (sz == 2'd1) return a[0];
    if (sz == 2'd2) return a[1:0] != 0;
    return 0;
  endfunction

  task automatic runReq(input bit wr, input logic [1:0] sz, input int cnt,
                        input logic [31:0] addr, input logic [32*MAXR-1:0] wd);
    bit multi = cnt > 1;
    logic [1:0] esz = multi ? 2'd2 : sz;
    logic [31:0] a = addr;
    int rem = cnt;
    int idx = 0;
    @(negedge clk);
    chk(reqReady, "R8 ready when idle", reqReady, 1);
    reqValid = 1; reqWrite = wr; reqSize = sz; reqCount = CW'(cnt); reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    if (isFault(sz, cnt, addr)) begin
      chk(faultFlag, "R3 fault raised", faultFlag, 1);
      for (int i = 0; i < 3; i++) begin
        chk(!arValid && !awValid && !wValid, "R3 no transaction after fault", {arValid, awValid, wValid}, 0);
        @(negedge clk);
      end
      return;
    end
    chk(!faultFlag, "R3 no fault on aligned", faultFlag, 0);
    while (rem > 0) begin
      int len = (wr && multi && !a[2] && rem >= 2) ? 2 : 1;
      logic [1:0] resp = ($urandom % 4 == 0) ? 2'b10 : 2'b00;
      if (wr) begin
        while (!awValid) @(negedge clk);
        chk(awAddr == a, multi ? "R6 burst address" : "R1 address", awAddr, a);
        chk(awLen == 8'(len - 1), multi ? "R6 burst length" : "R1 one beat", awLen, len - 1);
        chk(awSize == {1'b0, esz}, multi ? "R4 word size" : "R1 native size", awSize, esz);
        chk(awBurst == 2'b01, "R7 INCR", awBurst, 1);
        repeat ($urandom % 3) @(negedge clk);
        awReady = 1; @(negedge clk); awReady = 0;
        for (int b = 0; b < len; b++) begin
          logic [2:0] ba = a[2:0] + 3'(4 * b);
          logic [31:0] w = wd[(idx + b) * 32 +: 32];
          logic [7:0] es = expStrb(esz, ba);
          while (!wValid) @(negedge clk);
          chk(wStrb == es, "R2 strobe", wStrb, es);
          chk(wLast == (b == len - 1), "R6 last beat", wLast, b == len - 1);
          for (int l = 0; l < 8; l++)
            if (es[l]) chk(wData[l*8 +: 8] == w[(l - ba) * 8 +: 8], "R11 lane data",
                           wData[l*8 +: 8], w[(l - ba) * 8 +: 8]);
          wReady = 1; @(negedge clk); wReady = 0;
        end
        pause($urandom % 3);
        bValid = 1; bResp = resp; #1;
        chk(rspValid, "R10 write completion", rspValid, 1);
        chk(rspErr == (resp != 0), "R10 error flag", rspErr, resp != 0);
        chk(rspLast == (rem == len), "R10 last marker", rspLast, rem == len);
        @(negedge clk); bValid = 0;
      end else begin
        logic [63:0] rd = {$urandom, $urandom};
        logic [31:0] er;
        while (!arValid) @(negedge clk);
        chk(arAddr == a, multi ? "R5 read address" : "R1 address", arAddr, a);
        chk(arLen == 0, multi ? "R5 single beat" : "R1 one beat", arLen, 0);
        chk(arSize == {1'b0, esz}, multi ? "R4 word size" : "R1 native size", arSize, esz);
        chk(arBurst == 2'b01, "R7 INCR", arBurst, 1);
        repeat ($urandom % 3) @(negedge clk);
        arReady = 1; @(negedge clk); arReady = 0;
        pause($urandom % 3);
        er = expRead(esz, a[2:0], rd);
        rValid = 1; rData = rd; rResp = resp; #1;
        chk(rspValid, "R10 read completion", rspValid, 1);
        chk(rspData == er, "R10 read data", rspData, er);
        chk(rspErr == (resp != 0), "R10 error flag", rspErr, resp != 0);
        chk(rspLast == (rem == len), "R10 last marker", rspLast, rem == len);
        @(negedge clk); rValid = 0;
      end
      a += 32'(4 * len); rem -= len; idx += len;
    end
  endtask

  function automatic logic [32*MAXR-1:0] rndData();
    logic [32*MAXR-1:0] d;
    for (int i = 0; i < MAXR; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    int unsigned seedInit = $urandom(32'd20240611);
    rstN = 0; lowPower = 0; reqValid = 0; reqWrite = 0; reqSize = 0; reqCount = 1;
    reqAddr = 0; reqWdata = '0; arReady = 0; awReady = 0; wReady = 0;
    bValid = 0; bResp = 0; rValid = 0; rData = 0; rResp = 0;
    if (seedInit == 0) $display("seed");
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!arValid && !awValid && !wValid && !faultFlag && !rspValid, "R9 reset idle",
        {arValid, awValid, wValid, faultFlag, rspValid}, 0);
    chk(bReady && rReady && reqReady, "R8 readies after reset", {bReady, rReady, reqReady}, 3'b111);

    // directed: every size, both directions, lane corners
    runReq(1, 2'd0, 1, 32'h100 + 7, rndData());
    runReq(1, 2'd1, 1, 32'h100 + 6, rndData());
    runReq(1, 2'd2, 1, 32'h104, rndData());
    runReq(0, 2'd0, 1, 32'h203, rndData());
    runReq(0, 2'd1, 1, 32'h202, rndData());
    runReq(0, 2'd2, 1, 32'h204, rndData());
    // R6 five words from offset 0 (2,2,1) and offset 4 (1,2,2)
    runReq(1, 2'd2, 5, 32'h300, rndData());
    runReq(1, 2'd2, 5, 32'h304, rndData());
    runReq(1, 2'd2, 3, 32'h31C, rndData());
    runReq(0, 2'd2, 4, 32'h40C, rndData());
    // R3 faults
    runReq(1, 2'd1, 1, 32'h501, rndData());
    runReq(0, 2'd2, 1, 32'h502, rndData());
    runReq(1, 2'd2, 3, 32'h503, rndData());
    runReq(0, 2'd3, 1, 32'h500, rndData());

    // R8 low-power mode
    @(negedge clk);
    lowPower = 1; reqValid = 1; reqWrite = 1; reqSize = 0; reqCount = 1; reqAddr = 32'h600;
    @(negedge clk);
    chk(!bReady && !rReady, "R8 readies drop", {bReady, rReady}, 0);
    chk(!reqReady, "R8 request blocked", reqReady, 0);
    @(negedge clk);
    chk(!awValid && !arValid, "R8 nothing issued in low power", {awValid, arValid}, 0);
    reqValid = 0; lowPower = 0;
    @(negedge clk);
    chk(bReady && rReady, "R8 readies return", {bReady, rReady}, 3);

    // random mix
    for (int n = 0; n < 80; n++) begin
      bit wr = $urandom % 2;
      int cnt = ($urandom % 2) ? 1 : 2 + ($urandom % (MAXR - 1));
      logic [1:0] sz = 2'($urandom % 3);
      logic [31:0] ad = ($urandom % 4096);
      if ($urandom % 6 != 0) begin
        if (cnt > 1 || sz == 2) ad[1:0] = 0;
        else if (sz == 1) ad[0] = 0;
      end
      runReq(wr, sz, cnt, ad, rndData());
    end
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule